// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This execution unit operates on one byte operand and a single bit of it, chosen by a bit number. It sets, clears, inverts or tests that bit. It also moves the bit between the operand and the carry flag, and it folds the bit into carry with AND, OR or XOR. Each carry operation exists in two forms: one uses the bit as it is, the other uses its complement. The caller fetches the operand elsewhere and supplies it together with the current condition codes.

The unit returns the updated byte, a write-enable for that byte and the updated condition codes. All results are registered and appear one clock after the request. The condition-code nibble is packed as N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. The unit writes only the flag that the operation defines and carries every other flag through unchanged.

Top module: `bitop_unit`

## Requirements
- R1: A request taken with `in_valid` high produces `out_valid` high on the following cycle, and only then. Reset drives `out_valid`, `wr_en`, `byte_out` and `ccr_out` to zero.
- R2: Only bits 2:0 of `bit_num` choose the bit. Bit 3 of `bit_num` has no effect on any result.
- R3: Opcode 0 sets the selected bit, 1 clears it and 2 inverts it. All other bits are kept, and `wr_en` is high.
- R4: Opcode 3 (test) sets Z (`ccr_out[2]`) to the complement of the selected bit. `wr_en` is low and `byte_out` equals `byte_in`.
- R5: Opcode 4 copies the selected bit into C (`ccr_out[0]`). Opcode 5 copies its complement into C. Neither writes the byte back.
- R6: Opcode 6 replaces the selected bit with C. Opcode 7 replaces it with the complement of C. Both raise `wr_en` and keep the other bits.
- R7: Opcodes 8/9 give C AND bit and C AND NOT bit. Opcodes 10/11 give C OR bit and C OR NOT bit. Opcodes 12/13 give C XOR bit and C XOR NOT bit. None writes the byte back.
- R8: N and V always pass through. Z passes through except on test. C passes through on opcodes 0 to 3, 6 and 7.
- R9: Opcodes 14 and 15 write nothing. They return the byte and all flags unchanged.
- R10: `wr_en` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| bit_num | input | 4 | Bit number; bits 2:0 used |
| byte_in | input | 8 | Operand byte |
| ccr_in | input | 4 | Condition codes {N,Z,V,C} |
| out_valid | output | 1 | Result strobe |
| byte_out | output | 8 | Result byte |
| wr_en | output | 1 | Write-back enable for `byte_out` |
| ccr_out | output | 4 | Updated condition codes {N,Z,V,C} |

## Verification
A wrong mask or a wrong opcode decode shows on the very next result. It appears as a wrong bit in `byte_out`, a stray bit change or a wrong `wr_en`. A wrong flag route shows as an N, V or Z that was not passed through, or as a wrong C. The unit holds no state from one request to the next, so every fault is visible one cycle after the request that exposes it. For that reason the stimulus sweeps every opcode, every bit number (including the ignored top bit) and both carry values.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int W = 8,
  parameter int NUMW = 4,
  parameter int OPW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  op,
  input  logic [NUMW-1:0] bit_num,
  input  logic [W-1:0]    byte_in,
  input  logic [3:0]      ccr_in,
  output logic            out_valid,
  output logic [W-1:0]    byte_out,
  output logic            wr_en,
  output logic [3:0]      ccr_out
);
  localparam int IDXW = $clog2(W);

  localparam logic [OPW-1:0] OP_SET = 4'd0, OP_CLR = 4'd1, OP_INV = 4'd2, OP_TST = 4'd3,
                             OP_LD  = 4'd4, OP_ILD = 4'd5, OP_ST  = 4'd6, OP_IST = 4'd7,
                             OP_AND = 4'd8, OP_IAND = 4'd9, OP_OR = 4'd10, OP_IOR = 4'd11,
                             OP_XOR = 4'd12, OP_IXOR = 4'd13;

  logic [W-1:0] mask;
  logic         sel, c_in;
  logic [W-1:0] nxt_byte;
  logic         nxt_wr, nxt_c, nxt_z;

  assign mask = {{(W-1){1'b0}}, 1'b1} << bit_num[IDXW-1:0];
  assign sel  = |(byte_in & mask);
  assign c_in = ccr_in[0];

  always_comb begin
    nxt_byte = byte_in;
    nxt_wr   = 1'b0;
    nxt_c    = c_in;
    nxt_z    = ccr_in[2];
    case (op)
      OP_SET:  begin nxt_byte = byte_in | mask;  nxt_wr = 1'b1; end
      OP_CLR:  begin nxt_byte = byte_in & ~mask; nxt_wr = 1'b1; end
      OP_INV:  begin nxt_byte = byte_in ^ mask;  nxt_wr = 1'b1; end
      OP_TST:  nxt_z = ~sel;
      OP_LD:   nxt_c = sel;
      OP_ILD:  nxt_c = ~sel;
      OP_ST:   begin nxt_byte = (byte_in & ~mask) | (c_in ? mask : '0);  nxt_wr = 1'b1; end
      OP_IST:  begin nxt_byte = (byte_in & ~mask) | (!c_in ? mask : '0); nxt_wr = 1'b1; end
      OP_AND:  nxt_c = c_in & sel;
      OP_IAND: nxt_c = c_in & ~sel;
      OP_OR:   nxt_c = c_in | sel;
      OP_IOR:  nxt_c = c_in | ~sel;
      OP_XOR:  nxt_c = c_in ^ sel;
      OP_IXOR: nxt_c = c_in ^ ~sel;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      byte_out  <= '0;
      ccr_out   <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & nxt_wr;
      if (in_valid) begin
        byte_out <= nxt_byte;
        ccr_out  <= {ccr_in[3], nxt_z, ccr_in[1], nxt_c};
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int W = 8,
  parameter int NUMW = 4,
  parameter int OPW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OPW-1:0]  op,
  input logic [NUMW-1:0] bit_num,
  input logic [W-1:0]    byte_in,
  input logic [3:0]      ccr_in,
  input logic            out_valid,
  input logic [W-1:0]    byte_out,
  input logic            wr_en,
  input logic [3:0]      ccr_out
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);

  // R8
  nv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (ccr_out[3] == $past(ccr_in[3])) && (ccr_out[1] == $past(ccr_in[1])));

  // R3
  single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(byte_out ^ $past(byte_in)) <= 1);

  // R4
  readonly_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd3 || op == 4'd4 || op == 4'd5 || op >= 4'd8)) |=>
      (!wr_en && byte_out == $past(byte_in)));

  // R9
  reserved_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 4'd14) |=> (ccr_out == $past(ccr_in)));
endmodule

bind bitop_unit bitop_unit_chk #(.W(W), .NUMW(NUMW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .bit_num(bit_num),
  .byte_in(byte_in), .ccr_in(ccr_in), .out_valid(out_valid), .byte_out(byte_out),
  .wr_en(wr_en), .ccr_out(ccr_out));

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [3:0] bit_num = '0;
  logic [7:0] byte_in = '0;
  logic [3:0] ccr_in = '0;
  logic       out_valid, wr_en;
  logic [7:0] byte_out;
  logic [3:0] ccr_out;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] q_byte[$];
  logic       q_wr[$];
  logic [3:0] q_ccr[$];
  logic [3:0] q_op[$];

  always #4 clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .bit_num(bit_num),
    .byte_in(byte_in), .ccr_in(ccr_in), .out_valid(out_valid), .byte_out(byte_out),
    .wr_en(wr_en), .ccr_out(ccr_out));

  task automatic report(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [3:0] n, input logic [7:0] b, input logic [3:0] cc);
    logic [7:0] eb;
    logic       ew, ec, ez, bit_v;
    int         k;
    k = int'(n % 8);
    bit_v = b[k];
    eb = b; ew = 1'b0; ec = cc[0]; ez = cc[2];
    if (o == 0) begin eb[k] = 1'b1; ew = 1'b1; end
    else if (o == 1) begin eb[k] = 1'b0; ew = 1'b1; end
    else if (o == 2) begin eb[k] = !bit_v; ew = 1'b1; end
    else if (o == 3) ez = (bit_v == 1'b0);
    else if (o == 4) ec = bit_v;
    else if (o == 5) ec = !bit_v;
    else if (o == 6) begin eb[k] = cc[0]; ew = 1'b1; end
    else if (o == 7) begin eb[k] = !cc[0]; ew = 1'b1; end
    else if (o == 8) ec = cc[0] && bit_v;
    else if (o == 9) ec = cc[0] && !bit_v;
    else if (o == 10) ec = cc[0] || bit_v;
    else if (o == 11) ec = cc[0] || !bit_v;
    else if (o == 12) ec = cc[0] != bit_v;
    else if (o == 13) ec = cc[0] == bit_v;
    q_byte.push_back(eb);
    q_wr.push_back(ew);
    q_ccr.push_back({cc[3], ez, cc[1], ec});
    q_op.push_back(o);
    in_valid = 1'b1; op = o; bit_num = n; byte_in = b; ccr_in = cc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string req_of(input logic [3:0] o);
    if (o <= 2) return "R3";
    if (o == 3) return "R4";
    if (o <= 5) return "R5";
    if (o <= 7) return "R6";
    if (o <= 13) return "R7";
    return "R9";
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!out_valid) report("R10", {31'd0, wr_en}, 32'd0);
        if (out_valid) begin
          if (q_op.size() == 0) report("R1", 32'd1, 32'd0);
          else begin
            string r;
            logic [3:0] ecc;
            r = req_of(q_op[0]);
            ecc = q_ccr.pop_front();
            report(r, {24'd0, byte_out}, {24'd0, q_byte.pop_front()});
            report(r, {31'd0, wr_en}, {31'd0, q_wr.pop_front()});
            report("R8", {28'd0, ccr_out}, {28'd0, ecc});
            void'(q_op.pop_front());
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
    repeat (3) @(negedge clk);
    // R1 reset state
    report("R1", {28'd0, out_valid, wr_en, 2'b00}, 32'd0);
    report("R1", {20'd0, byte_out, ccr_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    report("R1", {31'd0, out_valid}, 32'd0);
    for (int o = 0; o < 16; o++)
      for (int n = 0; n < 16; n++)
        for (int p = 0; p < 4; p++)
          drive(4'(o), 4'(n), pats[p], 4'(n + p + o));
    // R2 bit 3 ignored: same stimulus with bit 3 set
    drive(4'd0, 4'd11, 8'h00, 4'h0);
    drive(4'd3, 4'd15, 8'h7F, 4'h0);
    for (int i = 0; i < 400; i++) begin
      drive(4'($urandom), 4'($urandom), 8'($urandom), 4'($urandom));
      if (i % 7 == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    report("R1", q_op.size(), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule